// File: doc/BRIEF.md
# Card Command Engine

This block runs the command phase of a memory-card host controller. Software programs a 6-bit command index and a 32-bit argument, written as two 16-bit halves. It then writes a configuration word. That write requests a command, and the command goes out on `cmd_issue` once the card clock is running. If the clock is stopped, the request is held until software starts the clock. A stop-transfer flag in the configuration word suppresses the launch.

After launch, the card's response arrives as a byte stream. The block stores each byte pair in a nine-entry, 16-bit response queue. When the stream ends, it compares the byte count with the length that the configured response type requires. The result is either an end-of-command-response status or a response timeout. A good response can start the data phase through a one-cycle `data_go` pulse. Every launch raises an end-of-command interrupt request. Software drains the response queue by repeated reads of one register.

Registers are selected by `reg_sel`:

| Select | Register |
|--------|----------|
| 0 | clock control |
| 1 | status |
| 2 | configuration |
| 3 | index |
| 4 | argument high |
| 5 | argument low |
| 6 | response queue |
| 7 | interrupt |

Read data appears on `reg_rdata` one cycle after `reg_rd`.

Top module: `card_cmd_engine`

## Requirements
- R1: The index register keeps the low 6 bits of a write and drives them on `cmd_index`. A read of it returns the index with bit 6 set.
- R2: A write to argument-high (select 4) replaces only `cmd_arg[31:16]`. A write to argument-low (select 5) replaces only `cmd_arg[15:0]`.
- R3: A configuration write (select 2) stores the data ANDed with 0x3DFF, and reads back that value.
- R4: A configuration write with stop-transfer (bit 10) clear, while the clock is on, pulses `cmd_issue` in the cycle after the write. While the clock is off, it only leaves the command pending.
- R5: Writing clock control (select 0) with bit 0 set turns the clock on and sets status bit 8. It also issues a pending command unless the stored stop-transfer bit is set. Writing bit 1 turns the clock off, clears status bit 8 and abandons any outstanding response.
- R6: Response type 0 (configuration bits 1:0 = 0) completes at launch with no response. It sets status bit 13.
- R7: Types 1 and 3 need at least 4 response bytes, and type 2 needs at least 16. A shorter response sets status bit 1 (timeout), leaves bit 13 clear and empties the response queue.
- R8: A good response sets status bit 13 and pulses `data_go` for one cycle only if configuration bit 2 (data enable) is set.
- R9: Every launch sets `end_cmd_irq`, which also reads as bit 0 of the interrupt register (select 7). Writing 1 to that bit clears it, and writing 0 has no effect.
- R10: The queue is cleared at launch. Entry i holds response byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Reads of select 6 return entries 0 to 8 in order, then zero.
- R11: A configuration write with stop-transfer clear clears status bits 1 and 13, and keeps bit 8.
- R12: Response bytes past the eighteenth, and bytes arriving with no command outstanding, change neither the queue nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after `reg_rd` |
| cmd_issue | output | 1 | One-cycle command launch pulse |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response byte valid |
| rsp_byte | input | 8 | Response byte |
| rsp_end | input | 1 | End of response (may be given alone for no bytes) |
| data_go | output | 1 | One-cycle data-phase start pulse |
| end_cmd_irq | output | 1 | End-of-command interrupt request |

## Verification
The assertions check several rules on every cycle:
- no launch while the clock is off and not being started;
- timeout and response-done are never set together;
- `data_go` only accompanies a done status;
- a launch always carries the interrupt;
- a stop write halts the clock and the wait;
- the queue pointer stays in range and the queue is empty after a clear.

Other behaviour can only be shown by the bench scenarios:
- the length threshold for each response type;
- the byte packing order;
- reads running past the ninth entry;
- the register masks;
- stray and excess bytes being ignored.

// File: rtl/ccmd_pkg.sv
// Package: shared encodings for the card command engine.
// Assumes a 16-bit register data path.
package ccmd_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [2:0] {
        SEL_CLK  = 3'd0,
        SEL_STAT = 3'd1,
        SEL_CFG  = 3'd2,
        SEL_IDX  = 3'd3,
        SEL_ARGH = 3'd4,
        SEL_ARGL = 3'd5,
        SEL_RESP = 3'd6,
        SEL_IRQ  = 3'd7
    } reg_sel_e;

    localparam logic [DATA_W-1:0] CFG_MASK = 16'h3DFF;
    localparam int CFG_STOP_BIT  = 10;
    localparam int CFG_DEN_BIT   = 2;
    localparam int ST_TOUT_BIT   = 1;
    localparam int ST_CLKON_BIT  = 8;
    localparam int ST_DONE_BIT   = 13;
    localparam int CLK_START_BIT = 0;
    localparam int CLK_STOP_BIT  = 1;
    localparam int IRQ_BIT       = 0;
endpackage

// File: rtl/ccmd_regs.sv
// Module: register file and read path of the card command engine.
// Holds index, argument and configuration, decodes write strobes, registers read data.
// Assumes reg_wr and reg_rd are not asserted together.
module ccmd_regs
    import ccmd_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] status_word,
    input  logic              irq_bit,
    input  logic [DATA_W-1:0] fifo_head,
    output logic [DATA_W-1:0] cfg_q,
    output logic              cfg_wr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              start_wr,
    output logic              stop_wr,
    output logic              irq_clr_wr,
    output logic              pop,
    output logic [IDX_W-1:0]  cmd_index,
    output logic [2*DATA_W-1:0] cmd_arg,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [DATA_W-1:0] IDX_FLAG = DATA_W'(1) << IDX_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    // Decode write strobes for the sequencer
    always_comb begin
        cfg_wr     = reg_wr && (sel == SEL_CFG);
        cfg_wdata  = reg_wdata & CFG_MASK;
        start_wr   = reg_wr && (sel == SEL_CLK) && reg_wdata[CLK_START_BIT];
        stop_wr    = reg_wr && (sel == SEL_CLK) && reg_wdata[CLK_STOP_BIT];
        irq_clr_wr = reg_wr && (sel == SEL_IRQ) && reg_wdata[IRQ_BIT];
        pop        = reg_rd && (sel == SEL_RESP);
    end

    // Storage for index, argument halves and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cmd_index <= '0;
            cmd_arg   <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_CFG:  cfg_q <= cfg_wdata;
                SEL_IDX:  cmd_index <= reg_wdata[IDX_W-1:0];
                SEL_ARGH: cmd_arg[2*DATA_W-1:DATA_W] <= reg_wdata;
                SEL_ARGL: cmd_arg[DATA_W-1:0] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Registered read multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_STAT: reg_rdata <= status_word;
                SEL_CFG:  reg_rdata <= cfg_q;
                SEL_IDX:  reg_rdata <= DATA_W'(cmd_index) | IDX_FLAG;
                SEL_ARGH: reg_rdata <= cmd_arg[2*DATA_W-1:DATA_W];
                SEL_ARGL: reg_rdata <= cmd_arg[DATA_W-1:0];
                SEL_RESP: reg_rdata <= fifo_head;
                SEL_IRQ:  reg_rdata <= DATA_W'(irq_bit);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    AST_IDX_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel == SEL_IDX) |=> reg_rdata[IDX_W]); // R1
endmodule

// File: rtl/ccmd_rsp_fifo.sv
// Module: response capture queue.
// Packs incoming bytes little-end-first into 16-bit entries and counts received bytes.
// Pops return the entries in order, then zero once all are read.
// Assumes clr has priority over a byte arriving in the same cycle.
module ccmd_rsp_fifo #(
    parameter int NUM_ENTRIES = 9,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_we,
    input  logic [7:0]       byte_in,
    input  logic             pop,
    output logic [15:0]      head,
    output logic [CNT_W-1:0] byte_cnt
);
    localparam int PTR_W = $clog2(NUM_ENTRIES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [15:0]      entry_q [NUM_ENTRIES];
    logic [PTR_W-1:0] rd_ptr;
    logic [NUM_ENTRIES-1:0] hit_lo, hit_hi;

    // Per-entry byte-slot match against the running byte count
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        assign hit_lo[e] = byte_we && (byte_cnt == CNT_W'(2*e));
        assign hit_hi[e] = byte_we && (byte_cnt == CNT_W'(2*e + 1));
    end

    // Entry storage: clear on request, otherwise fill the addressed half
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (!rst_n || clr)  entry_q[e] <= '0;
            else if (hit_lo[e]) entry_q[e][7:0]  <= byte_in;
            else if (hit_hi[e]) entry_q[e][15:8] <= byte_in;
        end
    end

    // Saturating received-byte counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                      byte_cnt <= '0;
        else if (byte_we && byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
    end

    // Read pointer advancing on each pop until past the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                                 rd_ptr <= '0;
        else if (pop && rd_ptr < PTR_W'(NUM_ENTRIES))      rd_ptr <= rd_ptr + 1'b1;
    end

    assign head = (rd_ptr < PTR_W'(NUM_ENTRIES)) ? entry_q[rd_ptr] : 16'h0000;

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= PTR_W'(NUM_ENTRIES)); // R10
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (byte_cnt == '0 && head == 16'h0000)); // R10
endmodule

// File: rtl/ccmd_seq.sv
// Module: launch and completion sequencer.
// Tracks clock enable, the pending request and the response wait.
// Judges the response length against the configured type and keeps the status and interrupt bits.
// Assumes a single register write per cycle.
module ccmd_seq
    import ccmd_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_q,
    input  logic              start_wr,
    input  logic              stop_wr,
    input  logic              irq_clr_wr,
    input  logic              rsp_valid,
    input  logic              rsp_end,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic              cmd_issue,
    output logic              data_go,
    output logic              end_cmd_irq,
    output logic              st_clk_en,
    output logic              st_tout,
    output logic              st_done,
    output logic              fifo_clr,
    output logic              byte_we
);
    logic pending_q, busy_q;
    logic issue_now, resp_close, resp_ok;
    logic [DATA_W-1:0] eff_cfg;
    logic [CNT_W:0] got, need;

    // Launch decision and response length check
    always_comb begin
        eff_cfg   = cfg_wr ? cfg_wdata : cfg_q;
        issue_now = (cfg_wr && !cfg_wdata[CFG_STOP_BIT] && st_clk_en) ||
                    (start_wr && pending_q && !cfg_q[CFG_STOP_BIT]);
        case (cfg_q[1:0])
            2'd0:    need = '0;
            2'd2:    need = (CNT_W+1)'(LONG_LEN);
            default: need = (CNT_W+1)'(SHORT_LEN);
        endcase
        got        = {1'b0, byte_cnt} + {{CNT_W{1'b0}}, rsp_valid};
        resp_ok    = got >= need;
        resp_close = busy_q && rsp_end && !cfg_wr && !stop_wr;
        fifo_clr   = issue_now || (resp_close && !resp_ok);
        byte_we    = busy_q && rsp_valid;
    end

    // State, status and interrupt update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0; busy_q <= 1'b0; st_clk_en <= 1'b0;
            st_tout <= 1'b0; st_done <= 1'b0; end_cmd_irq <= 1'b0;
            cmd_issue <= 1'b0; data_go <= 1'b0;
        end else begin
            cmd_issue <= issue_now;
            data_go   <= 1'b0;
            if (cfg_wr) begin
                pending_q <= 1'b1;
                busy_q    <= 1'b0;
            end
            if ((cfg_wr && !cfg_wdata[CFG_STOP_BIT]) || issue_now) begin
                st_tout <= 1'b0;
                st_done <= 1'b0;
            end
            if (start_wr) st_clk_en <= 1'b1;
            if (issue_now) begin
                pending_q   <= 1'b0;
                end_cmd_irq <= 1'b1;
                if (eff_cfg[1:0] == 2'd0) begin
                    st_done <= 1'b1;
                    data_go <= eff_cfg[CFG_DEN_BIT];
                    busy_q  <= 1'b0;
                end else begin
                    busy_q  <= 1'b1;
                end
            end else if (resp_close) begin
                busy_q <= 1'b0;
                if (resp_ok) begin
                    st_done <= 1'b1;
                    data_go <= cfg_q[CFG_DEN_BIT];
                end else begin
                    st_tout <= 1'b1;
                end
            end
            if (irq_clr_wr) end_cmd_irq <= 1'b0;
            if (stop_wr) begin
                st_clk_en <= 1'b0;
                busy_q    <= 1'b0;
            end
        end
    end

    AST_NO_ISSUE_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_clk_en && !start_wr) |=> !cmd_issue); // R4
    AST_TOUT_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_tout && st_done)); // R7
    AST_GO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |-> st_done); // R8
    AST_IRQ_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> end_cmd_irq); // R9
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!st_clk_en && !busy_q)); // R5
endmodule

// File: rtl/card_cmd_engine.sv
// Module: top of the card command engine.
// Connects the register file, the launch sequencer and the response queue, and assembles the status word.
// Assumes LONG_LEN does not exceed two bytes per queue entry.
module card_cmd_engine
    import ccmd_pkg::*;
#(
    parameter int NUM_ENTRIES = 9,
    parameter int IDX_W       = 6,
    parameter int SHORT_LEN   = 4,
    parameter int LONG_LEN    = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [2:0]   reg_sel,
    input  logic [15:0]  reg_wdata,
    output logic [15:0]  reg_rdata,
    output logic         cmd_issue,
    output logic [5:0]   cmd_index,
    output logic [31:0]  cmd_arg,
    input  logic         rsp_valid,
    input  logic [7:0]   rsp_byte,
    input  logic         rsp_end,
    output logic         data_go,
    output logic         end_cmd_irq
);
    localparam int CNT_W = $clog2(2*NUM_ENTRIES + 1) + 1;

    logic [DATA_W-1:0] cfg_q, cfg_wdata, status_word, fifo_head;
    logic cfg_wr, start_wr, stop_wr, irq_clr_wr, pop;
    logic st_clk_en, st_tout, st_done, fifo_clr, byte_we;
    logic [CNT_W-1:0] byte_cnt;

    // Status word with fixed bit positions for software
    always_comb begin
        status_word               = '0;
        status_word[ST_TOUT_BIT]  = st_tout;
        status_word[ST_CLKON_BIT] = st_clk_en;
        status_word[ST_DONE_BIT]  = st_done;
    end

    ccmd_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .status_word(status_word),
        .irq_bit(end_cmd_irq), .fifo_head(fifo_head), .cfg_q(cfg_q),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .start_wr(start_wr),
        .stop_wr(stop_wr), .irq_clr_wr(irq_clr_wr), .pop(pop),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .reg_rdata(reg_rdata)
    );

    ccmd_seq #(.CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .start_wr(start_wr), .stop_wr(stop_wr),
        .irq_clr_wr(irq_clr_wr), .rsp_valid(rsp_valid), .rsp_end(rsp_end),
        .byte_cnt(byte_cnt), .cmd_issue(cmd_issue), .data_go(data_go),
        .end_cmd_irq(end_cmd_irq), .st_clk_en(st_clk_en), .st_tout(st_tout),
        .st_done(st_done), .fifo_clr(fifo_clr), .byte_we(byte_we)
    );

    ccmd_rsp_fifo #(.NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .byte_we(byte_we),
        .byte_in(rsp_byte), .pop(pop), .head(fifo_head), .byte_cnt(byte_cnt)
    );
endmodule

// File: tb/card_cmd_engine_tb.sv
module card_cmd_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic cmd_issue, data_go, end_cmd_irq;
    logic [5:0] cmd_index;
    logic [31:0] cmd_arg;
    logic rsp_valid = 1'b0, rsp_end = 1'b0;
    logic [7:0] rsp_byte = '0;
    int n_chk = 0, n_fail = 0;
    logic go_seen;

    always #2 clk = ~clk;

    card_cmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_issue(cmd_issue), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_end(rsp_end),
        .data_go(data_go), .end_cmd_irq(end_cmd_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_sel = s;
        @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic send(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rsp_valid = 1'b1; rsp_byte = base + 8'(i); rsp_end = (i == n-1);
        end
        if (n == 0) begin
            @(negedge clk); rsp_valid = 1'b0; rsp_end = 1'b1;
        end
        @(negedge clk); go_seen = data_go; rsp_valid = 1'b0; rsp_end = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("reset cmd_issue", 32'(cmd_issue), 0);
        check("reset irq", 32'(end_cmd_irq), 0);
        rd(3'd1, d); check("reset status", 32'(d), 0);
        rd(3'd3, d); check("R1 index reset read", 32'(d), 32'h0040);
    endtask

    task automatic t_index_arg;
        logic [15:0] d;
        wr(3'd3, 16'hFFFF);
        check("R1 index port", 32'(cmd_index), 32'h3F);
        rd(3'd3, d); check("R1 index read flag", 32'(d), 32'h007F);
        wr(3'd4, 16'h1234); wr(3'd5, 16'hABCD);
        check("R2 arg both halves", cmd_arg, 32'h1234ABCD);
        wr(3'd4, 16'h5555);
        check("R2 arg high only", cmd_arg, 32'h5555ABCD);
        wr(3'd5, 16'h0F0F);
        check("R2 arg low only", cmd_arg, 32'h55550F0F);
    endtask

    task automatic t_cfg_mask;
        logic [15:0] d;
        wr(3'd2, 16'hFFFF);
        check("R4 no issue clock off", 32'(cmd_issue), 0);
        rd(3'd2, d); check("R3 cfg mask", 32'(d), 32'h3DFF);
        wr(3'd0, 16'h0001);
        check("R5 stop bit blocks start issue", 32'(cmd_issue), 0);
        rd(3'd1, d); check("R5 clock on status", 32'(d), 32'h0100);
        wr(3'd0, 16'h0002);
        rd(3'd1, d); check("R5 clock off status", 32'(d), 32'h0000);
    endtask

    task automatic t_issue_clock;
        logic [15:0] d;
        wr(3'd2, 16'h0001);
        check("R4 pending only", 32'(cmd_issue), 0);
        wr(3'd0, 16'h0001);
        check("R5 start issues pending", 32'(cmd_issue), 1);
        send(4, 8'h10);
        rd(3'd1, d); check("R8 good short status", 32'(d), 32'h2100);
        check("R8 no data_go without enable", 32'(go_seen), 0);
        wr(3'd2, 16'h0001);
        check("R4 immediate issue", 32'(cmd_issue), 1);
        rd(3'd1, d); check("R11 done cleared", 32'(d), 32'h0100);
        wr(3'd0, 16'h0002);
        send(4, 8'h20);
        rd(3'd1, d); check("R5 stop abandons response", 32'(d), 32'h0000);
        wr(3'd0, 16'h0001);
        check("R5 no reissue after launch", 32'(cmd_issue), 0);
    endtask

    task automatic t_type0;
        logic [15:0] d;
        wr(3'd2, 16'h0004);
        check("R6 type0 issue", 32'(cmd_issue), 1);
        check("R8 type0 data_go", 32'(data_go), 1);
        rd(3'd1, d); check("R6 type0 done", 32'(d), 32'h2100);
        wr(3'd2, 16'h0000);
        check("R8 type0 no data_go", 32'(data_go), 0);
    endtask

    task automatic t_type1_good;
        logic [15:0] d;
        wr(3'd2, 16'h0005);
        send(4, 8'hA0);
        check("R8 data_go with enable", 32'(go_seen), 1);
        rd(3'd6, d); check("R10 entry0", 32'(d), 32'hA1A0);
        rd(3'd6, d); check("R10 entry1", 32'(d), 32'hA3A2);
        rd(3'd6, d); check("R10 entry2 empty", 32'(d), 0);
    endtask

    task automatic t_short;
        logic [15:0] d;
        wr(3'd2, 16'h0002);
        send(15, 8'h30);
        check("R7 short no data_go", 32'(go_seen), 0);
        rd(3'd1, d); check("R7 type2 short timeout", 32'(d), 32'h0102);
        rd(3'd6, d); check("R7 queue emptied", 32'(d), 0);
        wr(3'd2, 16'h0001);
        rd(3'd1, d); check("R11 tout cleared", 32'(d), 32'h0100);
        send(0, 8'h00);
        rd(3'd1, d); check("R7 type1 no bytes timeout", 32'(d), 32'h0102);
        wr(3'd2, 16'h0003);
        send(4, 8'h50);
        rd(3'd1, d); check("R7 type3 four bytes ok", 32'(d), 32'h2100);
        wr(3'd2, 16'h0003);
        send(3, 8'h50);
        rd(3'd1, d); check("R7 type3 three bytes timeout", 32'(d), 32'h0102);
    endtask

    task automatic t_long_overflow;
        logic [15:0] d;
        wr(3'd2, 16'h0002);
        send(20, 8'h40);
        rd(3'd1, d); check("R7 type2 sixteen plus ok", 32'(d), 32'h2100);
        send(2, 8'hEE);
        rd(3'd1, d); check("R12 stray bytes status", 32'(d), 32'h2100);
        for (int i = 0; i < 9; i++) begin
            rd(3'd6, d);
            check("R10 R12 entry packing", 32'(d), {16'h0, 8'(8'h41 + 2*i), 8'(8'h40 + 2*i)});
        end
        rd(3'd6, d); check("R10 read past end", 32'(d), 0);
        rd(3'd6, d); check("R10 read past end again", 32'(d), 0);
    endtask

    task automatic t_irq;
        logic [15:0] d;
        rd(3'd7, d); check("R9 irq set", 32'(d), 1);
        wr(3'd7, 16'h0000);
        rd(3'd7, d); check("R9 write zero keeps", 32'(d), 1);
        wr(3'd7, 16'h0001);
        rd(3'd7, d); check("R9 write one clears", 32'(d), 0);
        check("R9 irq port cleared", 32'(end_cmd_irq), 0);
        wr(3'd2, 16'h0000);
        rd(3'd7, d); check("R9 irq on launch", 32'(d), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_arg();
        t_cfg_mask();
        t_issue_clock();
        t_type0();
        t_type1_good();
        t_short();
        t_long_overflow();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule